// File: doc/BRIEF.md
# Relocation and Limit Address Checker

This block protects and relocates memory accesses for a single memory partition. It sits between the logical address output of a processor and the memory bus. It holds two values: a partition base, which is the lowest physical address of the partition, and a partition size. Each request carries a logical address. The block compares that address with the size before any relocation is applied. When the address is in range, the block adds the base and issues a memory request carrying the physical address. When the address is out of range, the block raises an addressing trap and no memory request is issued.

Privileged software reloads the base and the size through a small write port, for example when switching processes, and this lets the partition move at run time. The block ignores writes made in user mode and flags each one for a single cycle. After reset the size is zero, so every access traps until software has programmed the block. The physical address appears only on the memory side and is never returned to the requester.

Top module: `rlc_guard`

## Requirements
- R1: During and right after reset, `mem_req`, `trap`, `cfg_denied` and `mem_paddr` are all zero, and base and size are both zero.
- R2: Before any privileged write to the size, every request traps one cycle after it is made.
- R3: A request whose logical address is strictly less than the size gives `mem_req`=1, `trap`=0 and `mem_paddr` = base + logical address in the following cycle.
- R4: A request whose logical address is equal to or greater than the size gives `trap`=1 and `mem_req`=0 in the following cycle. `trap` and `mem_req` are never high together.
- R5: In any cycle after a cycle with no request, both `mem_req` and `trap` are low.
- R6: A privileged write with `cfg_sel`=0 loads the base from `cfg_wdata`. A privileged write with `cfg_sel`=1 loads the size from the low LADDR_W+1 bits of `cfg_wdata`. A new value first applies to a request made in the cycle after the write. A request made in the same cycle as the write is checked against the old values.
- R7: A write with `cfg_priv`=0 changes neither the base nor the size, and `cfg_denied` is high for exactly the next cycle. A privileged write leaves `cfg_denied` low.
- R8: The physical address wraps modulo 2^PADDR_W.
- R9: `mem_paddr` is zero in every cycle in which `mem_req` is low, so a trapped access exposes no relocated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 selects the base, 1 selects the size |
| cfg_wdata | input | PADDR_W | Write data |
| cfg_priv | input | 1 | High when the writer is in privileged mode |
| cfg_denied | output | 1 | One-cycle flag raised after a user-mode write |
| req_valid | input | 1 | Access request from the processor |
| req_laddr | input | LADDR_W | Logical address of the request |
| mem_req | output | 1 | Registered memory request strobe |
| mem_paddr | output | PADDR_W | Registered physical address |
| trap | output | 1 | Registered addressing trap |

## Verification
The bench builds the block with LADDR_W=8 and PADDR_W=10. With these widths, a base near the top of the physical space pushes the sum past 2^10, so the wraparound in R8 can be checked with a few small addresses. The size register is 9 bits wide, so a size of 256 can be programmed. This makes every 8-bit logical address legal and tests the full-range edge of the comparison. Small widths also make the boundary pair at size-1 and at the size cheap to exercise after each reprogramming.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

    typedef enum logic {
        SEL_BASE = 1'b0,
        SEL_SIZE = 1'b1
    } cfg_sel_e;

    function automatic logic in_range(input logic [63:0] addr, input logic [63:0] size);
        return addr < size;
    endfunction

endpackage

// File: rtl/rlc_regs.sv
module rlc_regs
    import rlc_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int PADDR_W = 20,
    localparam int SIZE_W = LADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic [PADDR_W-1:0] cfg_wdata,
    input  logic               cfg_priv,
    output logic [PADDR_W-1:0] base_q,
    output logic [SIZE_W-1:0]  size_q,
    output logic               denied_q
);

    logic wr_ok;
    assign wr_ok = cfg_wr && cfg_priv;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            size_q   <= '0;
            denied_q <= 1'b0;
        end else begin
            denied_q <= cfg_wr && !cfg_priv;
            if (wr_ok && cfg_sel_e'(cfg_sel) == SEL_BASE)
                base_q <= cfg_wdata;
            if (wr_ok && cfg_sel_e'(cfg_sel) == SEL_SIZE)
                size_q <= cfg_wdata[SIZE_W-1:0];
        end
    end

    // R7: a user-mode write leaves both registers untouched and is flagged
    assert_user_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_priv) |=> ($stable(base_q) && $stable(size_q) && denied_q));

    // R6: a privileged write to the size lands in the next cycle
    assert_size_load_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_priv && cfg_sel) |=> (size_q == $past(cfg_wdata[SIZE_W-1:0])));

endmodule

// File: rtl/rlc_xlate.sv
module rlc_xlate
    import rlc_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int PADDR_W = 20,
    localparam int SIZE_W = LADDR_W + 1
) (
    input  logic               req_valid,
    input  logic [LADDR_W-1:0] req_laddr,
    input  logic [PADDR_W-1:0] base_q,
    input  logic [SIZE_W-1:0]  size_q,
    output logic               grant,
    output logic               fault,
    output logic [PADDR_W-1:0] paddr
);

    logic legal;

    always_comb begin
        legal = in_range(64'(req_laddr), 64'(size_q));
        grant = req_valid && legal;
        fault = req_valid && !legal;
        paddr = grant ? (base_q + PADDR_W'(req_laddr)) : '0;
    end

endmodule

// File: rtl/rlc_outreg.sv
module rlc_outreg #(
    parameter int PADDR_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               grant,
    input  logic               fault,
    input  logic [PADDR_W-1:0] paddr,
    output logic               mem_req,
    output logic               trap,
    output logic [PADDR_W-1:0] mem_paddr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req   <= 1'b0;
            trap      <= 1'b0;
            mem_paddr <= '0;
        end else begin
            mem_req   <= grant;
            trap      <= fault;
            mem_paddr <= grant ? paddr : '0;
        end
    end

    // R4: a trapped access never also strobes memory
    assert_trap_excl_req_R4: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && trap));

    // R9: no address leaks while the strobe is low
    assert_paddr_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> (mem_paddr == '0));

endmodule

// File: rtl/rlc_guard.sv
module rlc_guard
    import rlc_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int PADDR_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic [PADDR_W-1:0] cfg_wdata,
    input  logic               cfg_priv,
    output logic               cfg_denied,
    input  logic               req_valid,
    input  logic [LADDR_W-1:0] req_laddr,
    output logic               mem_req,
    output logic [PADDR_W-1:0] mem_paddr,
    output logic               trap
);

    localparam int SIZE_W = LADDR_W + 1;

    logic [PADDR_W-1:0] base_q;
    logic [SIZE_W-1:0]  size_q;
    logic               grant, fault;
    logic [PADDR_W-1:0] paddr;

    initial begin
        assert_width_fit_R6: assert (PADDR_W >= SIZE_W);
    end

    rlc_regs #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_priv(cfg_priv),
        .base_q(base_q), .size_q(size_q), .denied_q(cfg_denied)
    );

    rlc_xlate #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) u_xlate (
        .req_valid(req_valid), .req_laddr(req_laddr),
        .base_q(base_q), .size_q(size_q),
        .grant(grant), .fault(fault), .paddr(paddr)
    );

    rlc_outreg #(.PADDR_W(PADDR_W)) u_out (
        .clk(clk), .rst(rst), .grant(grant), .fault(fault), .paddr(paddr),
        .mem_req(mem_req), .trap(trap), .mem_paddr(mem_paddr)
    );

    // R5: an idle cycle yields neither strobe nor trap
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!mem_req && !trap));

    // R3 / R4: every output event answers a request one cycle earlier
    assert_req_answered_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (mem_req || trap));

endmodule

// File: tb/test_rlc_guard.sv
module test_rlc_guard;

    localparam int LW = 8;
    localparam int PW = 10;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [PW-1:0] cfg_wdata = '0;
    logic          cfg_priv = 1'b0;
    logic          cfg_denied;
    logic          req_valid = 1'b0;
    logic [LW-1:0] req_laddr = '0;
    logic          mem_req;
    logic [PW-1:0] mem_paddr;
    logic          trap;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rlc_guard #(.LADDR_W(LW), .PADDR_W(PW)) i_rlc_guard (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_priv(cfg_priv), .cfg_denied(cfg_denied),
        .req_valid(req_valid), .req_laddr(req_laddr),
        .mem_req(mem_req), .mem_paddr(mem_paddr), .trap(trap)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // One request; outputs are checked in the cycle after it is made.
    task automatic access(input int la, input bit exp_ok, input int exp_pa, input string tag);
        req_valid = 1'b1;
        req_laddr = LW'(la);
        step();
        req_valid = 1'b0;
        check({tag, " mem_req"}, int'(mem_req), int'(exp_ok));
        check({tag, " trap"}, int'(trap), int'(!exp_ok));
        check({tag, " paddr"}, int'(mem_paddr), exp_ok ? exp_pa : 0);
    endtask

    task automatic write_reg(input bit sel, input int data, input bit priv, input string tag);
        cfg_wr = 1'b1;
        cfg_sel = sel;
        cfg_wdata = PW'(data);
        cfg_priv = priv;
        step();
        cfg_wr = 1'b0;
        cfg_priv = 1'b0;
        check({tag, " denied"}, int'(cfg_denied), int'(!priv));
    endtask

    task automatic t_reset();
        check("R1 mem_req", int'(mem_req), 0);
        check("R1 trap", int'(trap), 0);
        check("R1 denied", int'(cfg_denied), 0);
        check("R1 paddr", int'(mem_paddr), 0);
    endtask

    task automatic t_unprogrammed();
        access(0, 1'b0, 0, "R2 addr0");
        access(255, 1'b0, 0, "R2 addr255");
    endtask

    task automatic t_basic();
        write_reg(1'b0, 100, 1'b1, "R6 base");
        write_reg(1'b1, 32, 1'b1, "R6 size");
        access(0, 1'b1, 100, "R3 low");
        access(31, 1'b1, 131, "R3 size-1");
        access(32, 1'b0, 0, "R4 at size");
        access(200, 1'b0, 0, "R4 beyond");
    endtask

    task automatic t_idle();
        step();
        check("R5 idle mem_req", int'(mem_req), 0);
        check("R5 idle trap", int'(trap), 0);
        check("R9 idle paddr", int'(mem_paddr), 0);
    endtask

    task automatic t_user_write();
        write_reg(1'b0, 500, 1'b0, "R7 user base");
        step();
        check("R7 denied one cycle", int'(cfg_denied), 0);
        write_reg(1'b1, 255, 1'b0, "R7 user size");
        access(10, 1'b1, 110, "R7 base kept");
        access(32, 1'b0, 0, "R7 size kept");
    endtask

    task automatic t_same_cycle();
        // the write and a request share the cycle: the old size of 32 applies
        cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = PW'(64); cfg_priv = 1'b1;
        req_valid = 1'b1; req_laddr = LW'(40);
        step();
        cfg_wr = 1'b0; cfg_priv = 1'b0; req_valid = 1'b0;
        check("R6 same-cycle trap", int'(trap), 1);
        check("R6 same-cycle mem_req", int'(mem_req), 0);
        access(40, 1'b1, 140, "R6 new size applied");
    endtask

    task automatic t_wrap_full();
        write_reg(1'b0, 1008, 1'b1, "R8 base");
        write_reg(1'b1, 256, 1'b1, "R8 size full");
        access(15, 1'b1, 1023, "R8 top edge");
        access(31, 1'b1, 15, "R8 wrap");
        access(255, 1'b1, (1008 + 255) % 1024, "R3 full range");
        write_reg(1'b1, 0, 1'b1, "R2 size zero");
        access(0, 1'b0, 0, "R4 size zero");
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst = 1'b0;
        t_reset();
        t_unprogrammed();
        t_basic();
        t_idle();
        t_user_write();
        t_same_cycle();
        t_wrap_full();
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule